// File: doc/BRIEF.md
# Two-Class Interrupt Priority Sorter

This block sits behind the register file and input sensing of an interrupt controller. It receives, for up to three banks of 32 lines, a pending vector, a mask vector, a per-line class steer bit and a per-line priority value. Every cycle it runs two independent arbitrations, one for the normal interrupt class and one for the fast interrupt class. For each class it holds a "new agreement" flag, a latched winner code and a request output toward the processor.

A class commits to a winner only while its agreement flag is armed. On the first clock edge where the flag is armed, at least one line is eligible and the global enable is high, the block stores the winning line code, clears the flag and raises the class output. The output then stays high, and the code stays frozen, until software writes a re-arm control bit for that class. That write drops the output and re-arms the flag. On the following edge the block evaluates again against the current inputs.

Top module: `intc_prio_sorter`

## Requirements
- R1: A line is eligible for a class only when its pending bit is 1, its mask bit is 0 (1 means masked) and its steer bit equals the class (steer 1 selects the fast class `fiq`, steer 0 selects the normal class `irq`).
- R2: Among eligible lines of a class, the one with the numerically smallest priority value is chosen.
- R3: When several eligible lines share the smallest priority value, the highest-numbered line is chosen, both within one bank and across banks.
- R4: When a class flag is armed, some line of that class is eligible, `glob_en` is 1 and no re-arm of that class is being written, then at the next rising clock edge the winner code is stored, the flag clears and the class output goes to 1. The output can only rise from an armed flag.
- R5: A write with `ctl_we`=1 and `ctl_rearm[0]`=1 drops `irq_o` and re-arms the normal class at the next edge. `ctl_rearm[1]` does the same for `fiq_o`. Each bit leaves the other class untouched.
- R6: While `glob_en` is 0, no class output rises. Eligible lines are committed on the first edge after `glob_en` returns to 1.
- R7: The stored code equals bank index times 32 plus the bit index within the bank. Line n sits at bit n of every vector, with priority in bits `n*PRIO_W +: PRIO_W`. The code is always below the line count.
- R8: After reset both outputs are 0, both codes are 0 and both flags are armed. The first eligible request is therefore committed without any control write.
- R9: While a class flag is clear, later changes to pending, mask or priority do not alter that class's code or output.
- R10: After a re-arm, if lines are still eligible, the output rises again one edge later with a winner computed from the inputs present at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_pend | input | NBANK*32 | Pending bit per line |
| line_mask | input | NBANK*32 | Mask bit per line, 1 = masked |
| line_fiq | input | NBANK*32 | Class steer per line, 1 = fast class |
| line_prio | input | NBANK*32*PRIO_W | Priority per line, lower value wins |
| glob_en | input | 1 | Global enable for committing new winners |
| ctl_we | input | 1 | Control write strobe |
| ctl_rearm | input | 2 | Bit 0 re-arms normal class, bit 1 re-arms fast class |
| irq_o | output | 1 | Normal-class request to the processor |
| fiq_o | output | 1 | Fast-class request to the processor |
| irq_code | output | CODE_W | Latched normal-class winner code |
| fiq_code | output | CODE_W | Latched fast-class winner code |

## Verification
The assertions assume that the line vectors are stable across each clock edge and that `ctl_rearm` has meaning only while `ctl_we` is high. They do not assume anything about how pending bits relate to the flags. The bench changes every input on the falling edge only and holds `ctl_we` for exactly one cycle per write. It returns `ctl_rearm` to zero together with the strobe. It also restores a quiet state, with nothing pending and both classes re-armed, between scenarios, so each scenario starts from a known flag state.

// File: rtl/intc_sort_pkg.sv
package intc_sort_pkg;
  localparam int LPB    = 32;
  localparam int MAX_PW = 6;

  typedef logic [MAX_PW-1:0] prio_t;

  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
    prio_t      prio;
  } bank_win_t;

  // scanning in ascending line order: a candidate of equal value replaces
  // the current best, so the highest line wins ties
  function automatic logic takes_over(logic cur_hit, prio_t cur_p, prio_t new_p);
    return !cur_hit || (new_p <= cur_p);
  endfunction

  function automatic logic [7:0] line_code(logic [1:0] bank, logic [4:0] idx);
    return {1'b0, bank, idx};
  endfunction
endpackage

// File: rtl/intc_bank_pick.sv
module intc_bank_pick
  import intc_sort_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic [LPB-1:0]    elig,
  input  logic [LPB*PW-1:0] prio,
  output bank_win_t         win
);
  always_comb begin
    win = '0;
    for (int i = 0; i < LPB; i++) begin
      if (elig[i] && takes_over(win.hit, win.prio, prio_t'(prio[i*PW +: PW]))) begin
        win.hit  = 1'b1;
        win.idx  = 5'(i);
        win.prio = prio_t'(prio[i*PW +: PW]);
      end
    end
  end
endmodule

// File: rtl/intc_class_merge.sv
module intc_class_merge
  import intc_sort_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int CW    = 7
) (
  input  bank_win_t [NBANK-1:0] wins,
  output logic                  hit,
  output logic [CW-1:0]         code
);
  prio_t best;

  always_comb begin
    hit  = 1'b0;
    best = '0;
    code = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (wins[b].hit && takes_over(hit, best, wins[b].prio)) begin
        hit  = 1'b1;
        best = wins[b].prio;
        code = CW'(line_code(2'(b), wins[b].idx));
      end
    end
  end
endmodule

// File: rtl/intc_agree_ctl.sv
module intc_agree_ctl #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          glob_en,
  input  logic          rearm,
  input  logic [CW-1:0] win_code,
  output logic          latch_ev,
  output logic          armed_q,
  output logic          out_q,
  output logic [CW-1:0] code_q
);
  assign latch_ev = armed_q && hit && glob_en && !rearm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (latch_ev) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      code_q  <= win_code;
    end
  end
endmodule

// File: rtl/intc_prio_sorter.sv
module intc_prio_sorter
  import intc_sort_pkg::*;
#(
  parameter int NBANK  = 3,
  parameter int PRIO_W = 5,
  localparam int NLINES = NBANK * LPB,
  localparam int CODE_W = $clog2(NLINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINES-1:0]        line_pend,
  input  logic [NLINES-1:0]        line_mask,
  input  logic [NLINES-1:0]        line_fiq,
  input  logic [NLINES*PRIO_W-1:0] line_prio,
  input  logic                     glob_en,
  input  logic                     ctl_we,
  input  logic [1:0]               ctl_rearm,
  output logic                     irq_o,
  output logic                     fiq_o,
  output logic [CODE_W-1:0]        irq_code,
  output logic [CODE_W-1:0]        fiq_code
);
  // per-class named events for the checker: index 0 = irq, 1 = fiq
  logic [1:0]             hit_w;
  logic [1:0]             latch_w;
  logic [1:0]             armed_w;
  logic [1:0]             out_w;
  logic [1:0]             rearm_w;
  logic [1:0][CODE_W-1:0] win_w;
  logic [1:0][CODE_W-1:0] code_w;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NLINES-1:0]     elig;
    bank_win_t [NBANK-1:0] bank_wins;

    assign elig       = line_pend & ~line_mask & ((c == 1) ? line_fiq : ~line_fiq);
    assign rearm_w[c] = ctl_we & ctl_rearm[c];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      intc_bank_pick #(.PW(PRIO_W)) u_pick (
        .elig (elig[b*LPB +: LPB]),
        .prio (line_prio[b*LPB*PRIO_W +: LPB*PRIO_W]),
        .win  (bank_wins[b])
      );
    end

    intc_class_merge #(.NBANK(NBANK), .CW(CODE_W)) u_merge (
      .wins (bank_wins),
      .hit  (hit_w[c]),
      .code (win_w[c])
    );

    intc_agree_ctl #(.CW(CODE_W)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_w[c]),
      .glob_en  (glob_en),
      .rearm    (rearm_w[c]),
      .win_code (win_w[c]),
      .latch_ev (latch_w[c]),
      .armed_q  (armed_w[c]),
      .out_q    (out_w[c]),
      .code_q   (code_w[c])
    );
  end

  assign irq_o    = out_w[0];
  assign fiq_o    = out_w[1];
  assign irq_code = code_w[0];
  assign fiq_code = code_w[1];
endmodule

// File: rtl/intc_sort_chk.sv
module intc_sort_chk #(
  parameter int CW = 7,
  parameter int NL = 96
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ctl_we,
  input logic [1:0]         ctl_rearm,
  input logic               glob_en,
  input logic [1:0]         latch,
  input logic [1:0]         armed,
  input logic [1:0]         outs,
  input logic [1:0][CW-1:0] codes
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    AST_OUT_EXCL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      outs[c] |-> !armed[c]); // R4
    AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(outs[c]) |-> ($past(armed[c]) && $past(glob_en))); // R4
    AST_LATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      latch[c] |=> (outs[c] && !armed[c])); // R4
    AST_REARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_rearm[c]) |=> (!outs[c] && armed[c])); // R5
    AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !outs[c]) |=> !outs[c]); // R6
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(codes[c]) < NL); // R7
    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !armed[c] |=> $stable(codes[c])); // R9
  end
endmodule

bind intc_prio_sorter intc_sort_chk #(.CW(CODE_W), .NL(NLINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_we    (ctl_we),
  .ctl_rearm (ctl_rearm),
  .glob_en   (glob_en),
  .latch     (latch_w),
  .armed     (armed_w),
  .outs      (out_w),
  .codes     (code_w)
);

// File: tb/sim_intc_prio_sorter.sv
`timescale 1ns/1ps
module sim_intc_prio_sorter;
  localparam int NB = 3;
  localparam int PW = 5;
  localparam int NL = NB * 32;
  localparam int CW = $clog2(NL);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    pend = '0, mask = '0, fsel = '0;
  logic [NL*PW-1:0] prio = '0;
  logic             glob_en = 1'b1;
  logic             ctl_we = 1'b0;
  logic [1:0]       ctl_rearm = '0;
  logic             irq_o, fiq_o;
  logic [CW-1:0]    irq_code, fiq_code;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  intc_prio_sorter #(.NBANK(NB), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .line_pend(pend), .line_mask(mask),
    .line_fiq(fsel), .line_prio(prio), .glob_en(glob_en), .ctl_we(ctl_we),
    .ctl_rearm(ctl_rearm), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_code(irq_code), .fiq_code(fiq_code)
  );

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_p(int line, int v);
    prio[line*PW +: PW] = PW'(v);
  endtask

  // independent model: scan downward, strict improvement only
  function automatic int ref_win(bit f);
    int best = -1;
    int bp = 0;
    for (int l = NL - 1; l >= 0; l--) begin
      if (pend[l] && !mask[l] && fsel[l] == f) begin
        int p = int'(prio[l*PW +: PW]);
        if (best < 0 || p < bp) begin best = l; bp = p; end
      end
    end
    return (best < 0) ? 0 : best;
  endfunction

  task automatic rearm(logic [1:0] bits);
    ctl_we = 1'b1; ctl_rearm = bits;
    step();
    ctl_we = 1'b0; ctl_rearm = '0;
  endtask

  task automatic quiet();
    pend = '0; mask = '0; fsel = '0; prio = '0; glob_en = 1'b1;
    rearm(2'b11);
    step();
  endtask

  task automatic t_reset();
    chk("R8 irq_o", irq_o, 0);
    chk("R8 fiq_o", fiq_o, 0);
    chk("R8 irq_code", irq_code, 0);
    chk("R8 fiq_code", fiq_code, 0);
    pend[40] = 1'b1;           // armed from reset: commits without a write
    step();
    chk("R8 first commit", irq_o, 1);
    chk("R7 code bank1 bit8", irq_code, 40);
    quiet();
  endtask

  task automatic t_elig();
    pend[5] = 1'b1; mask[5] = 1'b1;
    step(2);
    chk("R1 masked ignored", irq_o, 0);
    chk("R1 masked no fiq", fiq_o, 0);
    pend[6] = 1'b1; fsel[6] = 1'b1;
    step();
    chk("R1 steer to fiq", fiq_o, 1);
    chk("R1 fiq code", fiq_code, 6);
    chk("R1 irq stays low", irq_o, 0);
    quiet();
  endtask

  task automatic t_prio();
    pend[10] = 1; set_p(10, 7);
    pend[70] = 1; set_p(70, 3);
    pend[90] = 1; set_p(90, 9);
    step();
    chk("R2 lowest value", irq_code, 70);
    chk("R2 model", irq_code, ref_win(0));
    quiet();
    pend[3] = 1; pend[33] = 1; pend[65] = 1;
    set_p(3, 4); set_p(33, 4); set_p(65, 4);
    step();
    chk("R3 tie across banks", irq_code, 65);
    quiet();
    pend[2] = 1; pend[20] = 1; set_p(2, 1); set_p(20, 1); set_p(25, 1);
    pend[25] = 1; mask[25] = 1;
    step();
    chk("R3 tie in bank", irq_code, 20);
    quiet();
  endtask

  task automatic t_code();
    pend[95] = 1;
    step();
    chk("R7 last line", irq_code, 95);
    quiet();
    pend[32] = 1; fsel[32] = 1;
    step();
    chk("R7 bank1 bit0 fiq", fiq_code, 32);
    quiet();
  endtask

  task automatic t_global();
    glob_en = 1'b0;
    pend[12] = 1; set_p(12, 10);
    pend[50] = 1; fsel[50] = 1;
    step(3);
    chk("R6 irq blocked", irq_o, 0);
    chk("R6 fiq blocked", fiq_o, 0);
    glob_en = 1'b1;
    step();
    chk("R6 irq after enable", irq_o, 1);
    chk("R6 irq code", irq_code, 12);
    chk("R6 fiq after enable", fiq_o, 1);
    // later better arrival while flag clear
    pend[1] = 1; set_p(1, 0);
    step(2);
    chk("R9 code frozen", irq_code, 12);
    chk("R9 out held", irq_o, 1);
    rearm(2'b01);
    chk("R5 irq dropped", irq_o, 0);
    chk("R5 fiq untouched", fiq_o, 1);
    chk("R5 fiq code kept", fiq_code, 50);
    step();
    chk("R10 re-commit", irq_o, 1);
    chk("R10 fresh winner", irq_code, 1);
    rearm(2'b10);
    chk("R5 fiq dropped", fiq_o, 0);
    chk("R5 irq untouched", irq_o, 1);
    pend = '0;
    step(2);
    chk("R10 nothing eligible", fiq_o, 0);
    quiet();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_elig();
    t_prio();
    t_code();
    t_global();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule